// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer ratio N = P·B + A. A dual-modulus prescaler counts either P or P+1 input cycles per prescaler cycle. A coarse main counter (B) counts prescaler cycles. A fine swallow counter (A) holds the prescaler at P+1 for the first A prescaler cycles of every output period. Once every N input cycles the block emits a pulse that lasts one cycle. The modulus-control signal that ties the swallow counter to the prescaler is brought out so that it can be observed.

The ratio settings are shadowed. A new prescaler code, B or A is taken only when a period ends, or while reset is held, so a change never produces a runt period. A setting that breaks the legality rules raises an error flag and is not loaded. The block keeps running on the last legal setting. If reset is held while the inputs are illegal, a safe default of P=8, B=3, A=0 (N=24) is loaded.

A controller state machine sequences the counters. It has three states. HOLD is entered whenever reset is sampled high. SWALLOW is the part of the period in which the prescaler divides by P+1. MAIN is the part in which it divides by P. The transitions are:
- HOLD→SWALLOW or HOLD→MAIN on the first cycle after reset, chosen by whether A is nonzero.
- SWALLOW→MAIN when the last swallow cycle completes.
- SWALLOW or MAIN→SWALLOW or MAIN at the period end, chosen by the A value about to be loaded.
- Any state→HOLD on reset.

Top module: `pulse_swallow_div`

## Requirements
- R1: `div_out` is a single-cycle pulse that repeats every N = P·B + A cycles of `clk` while the setting is stable.
- R2: Prescaler code `psc_sel` selects the lower modulus P as follows: 2'b00 gives 8, 2'b01 gives 16, and both 2'b10 and 2'b11 give 32.
- R3: A setting with `b_val` below 3 is illegal. `cfg_err` is high in the cycle after such inputs are sampled.
- R4: A setting with `a_val` (0 to 31) greater than `b_val` is illegal. `cfg_err` is high in the cycle after such inputs are sampled, and is low after legal inputs are sampled.
- R5: While `rst` is high, the counters are held, and `div_out` and `mod_ctl` are low one cycle later. After `rst` falls, the first pulse appears N+1 cycles later: one start cycle followed by a full period.
- R6: `mod_ctl` is high during exactly the first A·(P+1) cycles of each period, starting with the pulse cycle, and is low for the rest of the period.
- R7: New settings take effect only at a period end. The period that is running when the inputs change keeps its old length.
- R8: An illegal setting is never loaded and the previous legal setting stays in use. If reset is held with illegal inputs, the default setting P=8, B=3, A=0 is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Active-high synchronous counter reset |
| psc_sel | input | 2 | Prescaler modulus code |
| b_val | input | 13 | Main counter value B |
| a_val | input | 5 | Swallow counter value A |
| div_out | output | 1 | Divided output, one pulse per N cycles |
| mod_ctl | output | 1 | Modulus control, high while the prescaler divides by P+1 |
| cfg_err | output | 1 | Registered flag for an illegal setting on the inputs |

## Verification
The bench changes settings exactly on a pulse. It expects the next period to keep the old length and only the one after to use the new ratio. A divider that loads its settings at once would show a shortened or stretched runt period. A equal to B and A equal to zero are driven as corner cases: a swallow counter with an off-by-one error either leaves `mod_ctl` high into the MAIN phase or skips a swallow, and the period then misses N by one or by P+1. Illegal B and A combinations, including a reset held with illegal inputs, check that the old setting or the default keeps being used, where a design without the check would divide by a garbage ratio. Codes 2'b10 and 2'b11 are both measured to catch a decode that maps 2'b11 to a different modulus.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int MOD_W = 6;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } ctl_state_e;

    function automatic logic [MOD_W-1:0] psc_to_mod(input logic [1:0] code);
        logic [MOD_W-1:0] m;
        unique case (code)
            2'b00:   m = MOD_W'(8);
            2'b01:   m = MOD_W'(16);
            default: m = MOD_W'(32);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/psd_cfg_shadow.sv
module psd_cfg_shadow
    import psd_pkg::*;
#(
    parameter int B_W     = 13,
    parameter int A_W     = 5,
    parameter int B_MIN   = 3,
    parameter int DEF_B   = 3,
    parameter int DEF_A   = 0,
    parameter int DEF_PSC = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [1:0]       psc_in,
    input  logic [B_W-1:0]   b_in,
    input  logic [A_W-1:0]   a_in,
    output logic [MOD_W-1:0] cur_p,
    output logic [B_W-1:0]   cur_b,
    output logic [A_W-1:0]   cur_a,
    output logic [A_W-1:0]   nxt_a,
    output logic             cfg_err
);

    logic             legal;
    logic [1:0]       psc_q, psc_d;
    logic [B_W-1:0]   b_q, b_d;
    logic [A_W-1:0]   a_q, a_d;

    always_comb begin
        legal = (b_in >= B_W'(B_MIN)) && (b_in >= B_W'(a_in));
        if (legal) begin
            psc_d = psc_in;
            b_d   = b_in;
            a_d   = a_in;
        end else if (rst) begin
            psc_d = 2'(DEF_PSC);
            b_d   = B_W'(DEF_B);
            a_d   = A_W'(DEF_A);
        end else begin
            psc_d = psc_q;
            b_d   = b_q;
            a_d   = a_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            psc_q <= psc_d;
            b_q   <= b_d;
            a_q   <= a_d;
        end
        cfg_err <= !legal;
    end

    assign cur_p = psc_to_mod(psc_q);
    assign cur_b = b_q;
    assign cur_a = a_q;
    assign nxt_a = a_d;

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
(
    input  logic             clk,
    input  logic             hold,
    input  logic             use_high,
    input  logic [MOD_W-1:0] p_low,
    output logic             pre_end
);

    logic [MOD_W-1:0] pcnt;
    logic [MOD_W-1:0] last;

    always_comb begin
        last    = use_high ? p_low : (p_low - MOD_W'(1));
        pre_end = !hold && (pcnt == last);
    end

    always_ff @(posedge clk) begin
        if (hold || pre_end) pcnt <= '0;
        else                 pcnt <= pcnt + MOD_W'(1);
    end

endmodule

// File: rtl/psd_swallow_fsm.sv
module psd_swallow_fsm
    import psd_pkg::*;
#(
    parameter int B_W = 13,
    parameter int A_W = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_end,
    input  logic [B_W-1:0] cur_b,
    input  logic [A_W-1:0] cur_a,
    input  logic [A_W-1:0] nxt_a,
    output logic           swallow,
    output logic           hold,
    output logic           period_end,
    output logic           pulse_q
);

    ctl_state_e     state_q, state_d;
    logic [B_W-1:0] bcnt_q, bcnt_d;
    logic [A_W-1:0] acnt_q, acnt_d;

    always_comb begin
        period_end = (state_q != ST_HOLD) && pre_end &&
                     (bcnt_q == (cur_b - B_W'(1)));
        state_d = state_q;
        bcnt_d  = bcnt_q;
        acnt_d  = acnt_q;
        unique case (state_q)
            ST_HOLD: begin
                bcnt_d  = '0;
                acnt_d  = cur_a;
                state_d = (cur_a != '0) ? ST_SWALLOW : ST_MAIN;
            end
            ST_SWALLOW: begin
                if (period_end) begin
                    bcnt_d  = '0;
                    acnt_d  = nxt_a;
                    state_d = (nxt_a != '0) ? ST_SWALLOW : ST_MAIN;
                end else if (pre_end) begin
                    bcnt_d = bcnt_q + B_W'(1);
                    acnt_d = acnt_q - A_W'(1);
                    if (acnt_q == A_W'(1)) state_d = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (period_end) begin
                    bcnt_d  = '0;
                    acnt_d  = nxt_a;
                    state_d = (nxt_a != '0) ? ST_SWALLOW : ST_MAIN;
                end else if (pre_end) begin
                    bcnt_d = bcnt_q + B_W'(1);
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            bcnt_q  <= '0;
            acnt_q  <= '0;
        end else begin
            state_q <= state_d;
            bcnt_q  <= bcnt_d;
            acnt_q  <= acnt_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= period_end;
    end

    assign swallow = (state_q == ST_SWALLOW);
    assign hold    = (state_q == ST_HOLD);

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int B_W     = 13,
    parameter int A_W     = 5,
    parameter int B_MIN   = 3,
    parameter int DEF_B   = 3,
    parameter int DEF_A   = 0,
    parameter int DEF_PSC = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     psc_sel,
    input  logic [B_W-1:0] b_val,
    input  logic [A_W-1:0] a_val,
    output logic           div_out,
    output logic           mod_ctl,
    output logic           cfg_err
);

    logic [MOD_W-1:0] cur_p;
    logic [B_W-1:0]   cur_b;
    logic [A_W-1:0]   cur_a, nxt_a;
    logic             pre_end, swallow, hold, period_end, pulse_q;

    psd_cfg_shadow #(
        .B_W(B_W), .A_W(A_W), .B_MIN(B_MIN),
        .DEF_B(DEF_B), .DEF_A(DEF_A), .DEF_PSC(DEF_PSC)
    ) u_cfg (
        .clk(clk), .rst(rst), .load(period_end),
        .psc_in(psc_sel), .b_in(b_val), .a_in(a_val),
        .cur_p(cur_p), .cur_b(cur_b), .cur_a(cur_a), .nxt_a(nxt_a),
        .cfg_err(cfg_err)
    );

    psd_prescaler u_pre (
        .clk(clk), .hold(hold), .use_high(swallow),
        .p_low(cur_p), .pre_end(pre_end)
    );

    psd_swallow_fsm #(.B_W(B_W), .A_W(A_W)) u_fsm (
        .clk(clk), .rst(rst), .pre_end(pre_end),
        .cur_b(cur_b), .cur_a(cur_a), .nxt_a(nxt_a),
        .swallow(swallow), .hold(hold),
        .period_end(period_end), .pulse_q(pulse_q)
    );

    assign div_out = pulse_q;
    assign mod_ctl = swallow;

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int B_W   = 13,
    parameter int A_W   = 5,
    parameter int MIN_N = 24
) (
    input logic           clk,
    input logic           rst,
    input logic [B_W-1:0] b_val,
    input logic [A_W-1:0] a_val,
    input logic           div_out,
    input logic           mod_ctl,
    input logic           cfg_err
);

    logic [15:0] gap;

    always_ff @(posedge clk) begin
        if (rst || div_out)  gap <= '0;
        else if (gap != '1)  gap <= gap + 16'd1;
    end

    p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    p_min_gap_r1: assert property (@(posedge clk) disable iff (rst)
        div_out |-> (gap >= 16'(MIN_N - 1)));

    p_low_b_flag_r3: assert property (@(posedge clk)
        (b_val < B_W'(3)) |=> cfg_err);

    p_a_over_b_flag_r4: assert property (@(posedge clk)
        (B_W'(a_val) > b_val) |=> cfg_err);

    p_hold_quiet_r5: assert property (@(posedge clk)
        rst |=> (!div_out && !mod_ctl));

    p_swallow_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_ctl) |-> (div_out || $past(rst, 2)));

endmodule

bind pulse_swallow_div psd_checker #(.B_W(B_W), .A_W(A_W)) u_chk (
    .clk(clk), .rst(rst), .b_val(b_val), .a_val(a_val),
    .div_out(div_out), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
);

// File: tb/pulse_swallow_div_tb.sv
`timescale 1ns/1ps
module pulse_swallow_div_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  psc_sel;
    logic [12:0] b_val;
    logic [4:0]  a_val;
    logic        div_out, mod_ctl, cfg_err;
    int          checks = 0;
    int          errors = 0;
    int          cur_n, cur_mc;

    always #4 clk = ~clk;

    pulse_swallow_div u_dut (
        .clk(clk), .rst(rst), .psc_sel(psc_sel), .b_val(b_val), .a_val(a_val),
        .div_out(div_out), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
    );

    function automatic int pmod(input logic [1:0] c);
        return (c == 2'b00) ? 8 : (c == 2'b01) ? 16 : 32;
    endfunction

    function automatic int nexp(input logic [1:0] c, input int b, input int a);
        return pmod(c) * b + a;
    endfunction

    function automatic int mcexp(input logic [1:0] c, input int a);
        return a * (pmod(c) + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] c, input int b, input int a);
        psc_sel = c;
        b_val   = 13'(b);
        a_val   = 5'(a);
    endtask

    // starts at a pulse cycle, ends at the next pulse cycle
    task automatic run_period(output int len, output int mc);
        len = 0;
        mc  = 0;
        do begin
            if (mod_ctl) mc++;
            len++;
            @(negedge clk);
        end while (!div_out && len < 70000);
    endtask

    task automatic to_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_out && n < 70000);
    endtask

    // apply a legal setting at a pulse: old period, then the new one
    task automatic change_cfg(input logic [1:0] c, input int b, input int a, input string req);
        int len, mc;
        set_cfg(c, b, a);
        run_period(len, mc);
        check(len == cur_n, "R7 old period kept", len, cur_n);
        cur_n  = nexp(c, b, a);
        cur_mc = mcexp(c, a);
        run_period(len, mc);
        check(len == cur_n, req, len, cur_n);
        check(mc == cur_mc, "R6 swallow cycles", mc, cur_mc);
    endtask

    task automatic illegal_cfg(input logic [1:0] c, input int b, input int a, input string req);
        int len, mc, n;
        set_cfg(c, b, a);
        @(negedge clk);
        check(cfg_err == 1'b1, req, int'(cfg_err), 1);
        if (!div_out) to_pulse(n);
        run_period(len, mc);
        check(len == cur_n, "R8 previous setting kept", len, cur_n);
        check(mc == cur_mc, "R8 swallow unchanged", mc, cur_mc);
    endtask

    initial begin
        #1520000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, len, mc;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        set_cfg(2'b00, 5, 2);
        repeat (3) @(negedge clk);
        check(div_out == 1'b0, "R5 div_out low in reset", int'(div_out), 0);
        check(mod_ctl == 1'b0, "R5 mod_ctl low in reset", int'(mod_ctl), 0);
        check(cfg_err == 1'b0, "R4 no error on legal inputs", int'(cfg_err), 0);
        rst = 1'b0;
        cur_n  = nexp(2'b00, 5, 2);
        cur_mc = mcexp(2'b00, 2);
        to_pulse(n);
        check(n == cur_n + 1, "R5 first pulse after release", n, cur_n + 1);
        run_period(len, mc);
        check(len == cur_n, "R1 period N=P*B+A", len, cur_n);
        check(mc == cur_mc, "R6 swallow cycles", mc, cur_mc);

        change_cfg(2'b01, 7, 3, "R2 code 01 gives 16");
        change_cfg(2'b10, 4, 1, "R2 code 10 gives 32");
        change_cfg(2'b11, 4, 1, "R2 code 11 gives 32");
        change_cfg(2'b00, 5, 5, "R1 A equal to B");
        change_cfg(2'b00, 3, 0, "R1 A zero, B minimum");
        change_cfg(2'b00, 300, 31, "R1 large B");
        change_cfg(2'b01, 9, 4, "R1 mid setting");

        illegal_cfg(2'b10, 2, 0, "R3 B below 3 flagged");
        illegal_cfg(2'b00, 4, 6, "R4 A above B flagged");
        set_cfg(2'b00, 8, 1);
        @(negedge clk);
        check(cfg_err == 1'b0, "R4 flag clears on legal inputs", int'(cfg_err), 0);
        to_pulse(n);
        cur_n  = nexp(2'b00, 8, 1);
        cur_mc = mcexp(2'b00, 1);
        run_period(len, mc);
        check(len == cur_n, "R7 legal setting loaded at boundary", len, cur_n);

        // reset with illegal inputs falls back to the default
        rst = 1'b1;
        set_cfg(2'b11, 1, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cur_n  = 24;
        cur_mc = 0;
        to_pulse(n);
        check(n == 25, "R8 default after reset", n, 25);
        change_cfg(2'b01, 6, 2, "R1 after default");

        for (int i = 0; i < 25; i++) begin
            logic [1:0] c;
            int a, b;
            c = 2'($urandom % 4);
            a = int'($urandom % 32);
            b = a + int'($urandom % 10);
            if (b < 3) b = 3;
            change_cfg(c, b, a, "R1 random setting");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule